// File: doc/BRIEF.md
# Display List Sequencer

This block walks a display list held in memory, one instruction byte at a time, and decides for each scan line which line mode is in force and where the screen data starts. Each instruction byte names a mode and a row height. It may carry a flag that asks for a CPU interrupt when its last scan line begins. It may also carry a load flag, which makes the sequencer read two more bytes as a fresh screen memory pointer. Bytes come in over a simple request/valid read port. The sequencer asks for a byte only when the running instruction has used up its lines and a scan-line strobe arrives.

The interrupt reaches the CPU as a one-cycle pulse, gated by an enable register that software writes. A sticky status bit records that the pulse fired, and a clear strobe resets it. Instruction fetching can be switched off. The sequencer then stops reading memory and repeats the last mode on every line, while the screen pointer keeps stepping row by row. The screen pointer never leaves its 4 KiB block by counting. Only a load instruction moves it to another block.

Top module: `dlseq_top`

## Requirements
- R1: After reset nmi_o, nmi_status_o, mem_req_o, mode_o and scan_addr_o are all zero, blank_o is one, and the first list byte is read from address DL_BASE (default 0x0000).
- R2: When line_strobe_i is seen while no lines of the current instruction remain and dma_en_i is 1, mem_req_o rises with mem_addr_o equal to the next list address and both hold until a cycle with mem_valid_i high. Each accepted byte advances the list address by one.
- R3: mode_o is bits 3..0 of the last fetched instruction. Rows per instruction by mode: 2,4,6,8 give 8 lines; 3 gives 10; 5,7 give 16; 9,A give 4; B,D give 2; 1,C,E,F give 1.
- R4: Modes 0 and 1 are blank (blank_o=1) and leave scan_addr_o unchanged. Mode 0 lasts (bits 6..4)+1 lines.
- R5: A byte with mode 2..F and (byte AND 0x70)=0x40 is followed by two bytes, low first, that load scan_addr_o. A blank byte with the same bits reads no address bytes.
- R6: For an instruction with bit 7 set, nmi_o pulses high for exactly one cycle, one clock after its last scan line starts, and only when the enable bit is set.
- R7: A write with nmien_we_i loads the enable register. Only bit 7 matters: 0x80 enables and any value with bit 7 clear masks.
- R8: nmi_status_o is set with every nmi_o pulse and cleared by status_clr_i. When both happen in the same cycle, set wins.
- R9: When the last line of a non-blank instruction starts, the low 12 bits of scan_addr_o advance by ROW_BYTES (default 40) modulo 4096. Bits 15..12 are unchanged.
- R10: With dma_en_i at 0 when a new instruction is due, no memory read is made. The last mode repeats with its row count and the pointer still advances per R9, but the interrupt flag is not repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_strobe_i | input | 1 | One-cycle pulse at the start of each scan line |
| dma_en_i | input | 1 | Instruction fetch enable |
| mem_req_o | output | 1 | Read request to list memory |
| mem_addr_o | output | 16 | List byte address |
| mem_valid_i | input | 1 | Read data valid, completes the request |
| mem_data_i | input | 8 | Read data |
| nmien_we_i | input | 1 | Interrupt enable register write strobe |
| nmien_wdata_i | input | 8 | Interrupt enable write data |
| status_clr_i | input | 1 | Clears the interrupt status bit |
| nmi_o | output | 1 | One-cycle interrupt pulse |
| nmi_status_o | output | 1 | Sticky interrupt status |
| mode_o | output | 4 | Current line mode |
| blank_o | output | 1 | Current mode is blank |
| scan_addr_o | output | 16 | Screen memory pointer |

## Verification
The interrupt status bit can be set by a starting flagged line and cleared by software in the same clock. The bench provokes this by reading memory with no latency. It holds status_clr_i high from the strobe through the edge that starts the last line, so the set and the clear land on the same edge. It then requires nmi_o and nmi_status_o to both read one just after that edge, and a lone clear afterwards to drop the status. A second overlap exists between a fetch pause and the row boundary. The bench switches fetching off between instructions, and judges that the pointer still steps while mode, read count and interrupt count stay put.

// File: rtl/dlseq_pkg.sv
package dlseq_pkg;
  localparam int AW     = 16;
  localparam int CW     = 5;
  localparam int PAGE_W = 12;

  typedef enum logic [2:0] {S_IDLE, S_OP, S_LO, S_HI, S_LINE} seq_state_e;

  function automatic logic is_blank(input logic [3:0] mode);
    return mode < 4'h2;
  endfunction

  function automatic logic [CW-1:0] rows_of(input logic [7:0] op);
    logic [CW-1:0] r;
    case (op[3:0])
      4'h0:                    r = {2'b00, op[6:4]} + 5'd1;
      4'h3:                    r = 5'd10;
      4'h5, 4'h7:              r = 5'd16;
      4'h2, 4'h4, 4'h6, 4'h8:  r = 5'd8;
      4'h9, 4'hA:              r = 5'd4;
      4'hB, 4'hD:              r = 5'd2;
      default:                 r = 5'd1;
    endcase
    return r;
  endfunction

  function automatic logic is_lms(input logic [7:0] op);
    return !is_blank(op[3:0]) && ((op & 8'h70) == 8'h40);
  endfunction
endpackage

// File: rtl/dlseq_fetch.sv
module dlseq_fetch
  import dlseq_pkg::*;
#(
  parameter logic [AW-1:0] DL_BASE = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_strobe_i,
  input  logic          dma_en_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_valid_i,
  input  logic [7:0]    mem_data_i,
  output logic [3:0]    mode_o,
  output logic          line_go_o,
  output logic          last_o,
  output logic          irq_o,
  output logic          lms_we_o,
  output logic [AW-1:0] lms_addr_o
);
  seq_state_e    state_q;
  logic [AW-1:0] dl_ptr_q;
  logic [7:0]    op_q;
  logic [7:0]    lo_q;
  logic [CW-1:0] cnt_q;
  logic          irq_q;
  logic          accept;

  assign mem_req_o  = (state_q == S_OP) || (state_q == S_LO) || (state_q == S_HI);
  assign mem_addr_o = dl_ptr_q;
  assign accept     = mem_req_o && mem_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      dl_ptr_q <= DL_BASE;
      op_q     <= '0;
      lo_q     <= '0;
      cnt_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (line_strobe_i) begin
          if (cnt_q != '0) begin
            state_q <= S_LINE;
          end else if (dma_en_i) begin
            state_q <= S_OP;
          end else begin
            // fetch paused: replay last mode without its interrupt flag
            cnt_q   <= rows_of(op_q);
            irq_q   <= 1'b0;
            state_q <= S_LINE;
          end
        end
        S_OP: if (accept) begin
          op_q     <= mem_data_i;
          irq_q    <= mem_data_i[7];
          cnt_q    <= rows_of(mem_data_i);
          dl_ptr_q <= dl_ptr_q + 1'b1;
          state_q  <= is_lms(mem_data_i) ? S_LO : S_LINE;
        end
        S_LO: if (accept) begin
          lo_q     <= mem_data_i;
          dl_ptr_q <= dl_ptr_q + 1'b1;
          state_q  <= S_HI;
        end
        S_HI: if (accept) begin
          dl_ptr_q <= dl_ptr_q + 1'b1;
          state_q  <= S_LINE;
        end
        S_LINE: begin
          cnt_q   <= cnt_q - 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign mode_o     = op_q[3:0];
  assign line_go_o  = (state_q == S_LINE);
  assign last_o     = (cnt_q == CW'(1));
  assign irq_o      = irq_q;
  assign lms_we_o   = (state_q == S_HI) && accept;
  assign lms_addr_o = {mem_data_i, lo_q};
endmodule

// File: rtl/dlseq_scan.sv
module dlseq_scan
  import dlseq_pkg::*;
#(
  parameter int ROW_BYTES = 40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lms_we_i,
  input  logic [AW-1:0] lms_addr_i,
  input  logic          adv_i,
  output logic [AW-1:0] scan_addr_o
);
  localparam logic [PAGE_W-1:0] STEP = PAGE_W'(ROW_BYTES);

  logic [AW-1:0] scan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       scan_q <= '0;
    else if (lms_we_i) scan_q <= lms_addr_i;
    else if (adv_i)    scan_q <= {scan_q[AW-1:PAGE_W], scan_q[PAGE_W-1:0] + STEP};
  end

  assign scan_addr_o = scan_q;
endmodule

// File: rtl/dlseq_nmi.sv
module dlseq_nmi (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trig_i,
  input  logic       en_we_i,
  input  logic [7:0] en_wdata_i,
  input  logic       clr_i,
  output logic       nmi_o,
  output logic       status_o
);
  logic en_q, nmi_q, status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      nmi_q    <= 1'b0;
      status_q <= 1'b0;
    end else begin
      if (en_we_i) en_q <= (en_wdata_i & 8'h80) != 8'h00;
      nmi_q <= trig_i && en_q;
      if (trig_i && en_q) status_q <= 1'b1;
      else if (clr_i)     status_q <= 1'b0;
    end
  end

  assign nmi_o    = nmi_q;
  assign status_o = status_q;
endmodule

// File: rtl/dlseq_top.sv
module dlseq_top
  import dlseq_pkg::*;
#(
  parameter logic [15:0] DL_BASE   = 16'h0000,
  parameter int          ROW_BYTES = 40
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        line_strobe_i,
  input  logic        dma_en_i,
  output logic        mem_req_o,
  output logic [15:0] mem_addr_o,
  input  logic        mem_valid_i,
  input  logic [7:0]  mem_data_i,
  input  logic        nmien_we_i,
  input  logic [7:0]  nmien_wdata_i,
  input  logic        status_clr_i,
  output logic        nmi_o,
  output logic        nmi_status_o,
  output logic [3:0]  mode_o,
  output logic        blank_o,
  output logic [15:0] scan_addr_o
);
  logic          line_go, last, irq, lms_we;
  logic [AW-1:0] lms_addr;
  logic [3:0]    mode;

  dlseq_fetch #(.DL_BASE(DL_BASE)) u_fetch (
    .clk_i, .rst_ni, .line_strobe_i, .dma_en_i,
    .mem_req_o, .mem_addr_o, .mem_valid_i, .mem_data_i,
    .mode_o(mode), .line_go_o(line_go), .last_o(last), .irq_o(irq),
    .lms_we_o(lms_we), .lms_addr_o(lms_addr)
  );

  dlseq_scan #(.ROW_BYTES(ROW_BYTES)) u_scan (
    .clk_i, .rst_ni,
    .lms_we_i(lms_we), .lms_addr_i(lms_addr),
    .adv_i(line_go && last && !is_blank(mode)),
    .scan_addr_o
  );

  dlseq_nmi u_nmi (
    .clk_i, .rst_ni,
    .trig_i(line_go && last && irq),
    .en_we_i(nmien_we_i), .en_wdata_i(nmien_wdata_i),
    .clr_i(status_clr_i),
    .nmi_o, .status_o(nmi_status_o)
  );

  assign mode_o  = mode;
  assign blank_o = is_blank(mode);
endmodule

// File: rtl/dlseq_chk.sv
module dlseq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_o,
  input logic [15:0] mem_addr_o,
  input logic        mem_valid_i,
  input logic        nmi_o,
  input logic        nmi_status_o,
  input logic [3:0]  mode_o,
  input logic [15:0] scan_addr_o
);
  AST_NMI_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |=> !nmi_o); // R6
  AST_STATUS_WITH_NMI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> nmi_status_o); // R8
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o))); // R2
  AST_MODE_ONLY_ON_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && mem_valid_i) |=> $stable(mode_o)); // R3
  AST_PAGE_ONLY_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && mem_valid_i) |=> $stable(scan_addr_o[15:12])); // R9
endmodule

bind dlseq_top dlseq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .mem_valid_i(mem_valid_i), .nmi_o(nmi_o), .nmi_status_o(nmi_status_o),
  .mode_o(mode_o), .scan_addr_o(scan_addr_o)
);

// File: tb/dlseq_top_tb_top.sv
`timescale 1ns/1ps
module dlseq_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        line_strobe_i = 1'b0;
  logic        dma_en_i = 1'b1;
  logic        mem_req_o;
  logic [15:0] mem_addr_o;
  logic        mem_valid_i;
  logic [7:0]  mem_data_i;
  logic        nmien_we_i = 1'b0;
  logic [7:0]  nmien_wdata_i = 8'h00;
  logic        status_clr_i = 1'b0;
  logic        nmi_o, nmi_status_o, blank_o;
  logic [3:0]  mode_o;
  logic [15:0] scan_addr_o;

  logic [7:0] mem [0:255];
  int lat = 0;
  int wcnt = 0;
  int nmi_cnt = 0;
  int fetch_cnt = 0;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  assign mem_valid_i = mem_req_o && (wcnt >= lat);
  assign mem_data_i  = mem[mem_addr_o[7:0]];

  always @(posedge clk_i) begin
    if (mem_req_o && !mem_valid_i) wcnt <= wcnt + 1;
    else wcnt <= 0;
    if (nmi_o) nmi_cnt <= nmi_cnt + 1;
    if (mem_req_o && mem_valid_i) fetch_cnt <= fetch_cnt + 1;
  end

  dlseq_top dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input int l);
    rst_ni = 1'b0;
    line_strobe_i = 1'b0;
    dma_en_i = 1'b1;
    status_clr_i = 1'b0;
    nmien_we_i = 1'b0;
    lat = l;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic write_en(input logic [7:0] v);
    @(negedge clk_i) begin nmien_we_i = 1'b1; nmien_wdata_i = v; end
    @(negedge clk_i) nmien_we_i = 1'b0;
  endtask

  task automatic do_line();
    @(negedge clk_i) line_strobe_i = 1'b1;
    @(negedge clk_i) line_strobe_i = 1'b0;
    repeat (18) @(negedge clk_i);
  endtask

  task automatic t_reset();
    do_reset(0);
    chk("R1 nmi", nmi_o, 0);
    chk("R1 status", nmi_status_o, 0);
    chk("R1 req", mem_req_o, 0);
    chk("R1 mode", mode_o, 0);
    chk("R1 blank", blank_o, 1);
    chk("R1 scan", scan_addr_o, 0);
  endtask

  task automatic t_blank_irq();
    int n0, f0;
    do_reset(2);
    mem[0] = 8'hF0; mem[1] = 8'h40; mem[2] = 8'h0F;
    write_en(8'h80);
    n0 = nmi_cnt; f0 = fetch_cnt;
    for (int i = 0; i < 7; i++) do_line();
    chk("R4 no nmi before last blank line", nmi_cnt - n0, 0);
    do_line();
    chk("R6 nmi on 8th blank line", nmi_cnt - n0, 1);
    chk("R4 blank mode", blank_o, 1);
    chk("R4 scan unchanged", scan_addr_o, 0);
    chk("R2 one byte per blank instr", fetch_cnt - f0, 1);
    for (int i = 0; i < 5; i++) do_line();
    chk("R5 blank with load bits reads no address", fetch_cnt - f0, 2);
    do_line();
    chk("R5 next op read", fetch_cnt - f0, 3);
    chk("R3 mode F", mode_o, 4'hF);
    chk("R9 advance from zero", scan_addr_o, 16'h0028);
  endtask

  task automatic t_mask();
    int n0;
    do_reset(1);
    mem[0] = 8'h80; mem[1] = 8'h80;
    write_en(8'h7F);
    n0 = nmi_cnt;
    do_line();
    chk("R7 bit7 clear masks", nmi_cnt - n0, 0);
    chk("R7 status stays clear", nmi_status_o, 0);
    write_en(8'h80);
    do_line();
    chk("R7 0x80 enables", nmi_cnt - n0, 1);
  endtask

  task automatic t_lms_rows();
    int f0;
    do_reset(3);
    mem[0] = 8'h42; mem[1] = 8'h00; mem[2] = 8'h30; mem[3] = 8'h0F;
    f0 = fetch_cnt;
    @(negedge clk_i) line_strobe_i = 1'b1;
    @(negedge clk_i) line_strobe_i = 1'b0;
    @(negedge clk_i);
    chk("R2 req while waiting", mem_req_o, 1);
    chk("R2 addr from base", mem_addr_o, 16'h0000);
    repeat (18) @(negedge clk_i);
    for (int i = 0; i < 6; i++) do_line();
    chk("R3 mode 2", mode_o, 4'h2);
    chk("R5 pointer loaded", scan_addr_o, 16'h3000);
    do_line();
    chk("R9 advance after 8 lines", scan_addr_o, 16'h3028);
    do_line();
    chk("R3 next instr after 8 lines", mode_o, 4'hF);
    chk("R9 advance mode F", scan_addr_o, 16'h3050);
    chk("R5 address bytes consumed", fetch_cnt - f0, 4);
  endtask

  task automatic t_wrap();
    do_reset(1);
    mem[0] = 8'h4E; mem[1] = 8'hF0; mem[2] = 8'h0F;
    mem[3] = 8'h0E;
    mem[4] = 8'h4E; mem[5] = 8'h00; mem[6] = 8'h10;
    do_line();
    chk("R9 wrap in 4K block", scan_addr_o, 16'h0018);
    do_line();
    chk("R9 plain advance", scan_addr_o, 16'h0040);
    do_line();
    chk("R5 load moves block", scan_addr_o, 16'h1028);
  endtask

  task automatic t_dma_off();
    int n0, f0;
    do_reset(1);
    mem[0] = 8'hCF; mem[1] = 8'h00; mem[2] = 8'h20; mem[3] = 8'h8E;
    write_en(8'h80);
    n0 = nmi_cnt; f0 = fetch_cnt;
    do_line();
    chk("R6 flagged load instr", nmi_cnt - n0, 1);
    chk("R5 scan", scan_addr_o, 16'h2028);
    dma_en_i = 1'b0;
    do_line();
    chk("R10 repeat advances", scan_addr_o, 16'h2050);
    do_line();
    do_line();
    chk("R10 repeat advances 3", scan_addr_o, 16'h20A0);
    chk("R10 mode repeated", mode_o, 4'hF);
    chk("R10 no reads", fetch_cnt - f0, 3);
    chk("R10 no repeated nmi", nmi_cnt - n0, 1);
    dma_en_i = 1'b1;
    do_line();
    chk("R10 resume fetch", mode_o, 4'hE);
    chk("R6 nmi after resume", nmi_cnt - n0, 2);
    chk("R2 resume address", fetch_cnt - f0, 4);
  endtask

  task automatic t_status();
    do_reset(0);
    mem[0] = 8'h8F;
    write_en(8'h80);
    @(negedge clk_i) begin line_strobe_i = 1'b1; status_clr_i = 1'b1; end
    @(negedge clk_i) line_strobe_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i) status_clr_i = 1'b0;
    chk("R6 nmi timing", nmi_o, 1);
    chk("R8 set wins over clear", nmi_status_o, 1);
    repeat (4) @(negedge clk_i);
    chk("R8 sticky", nmi_status_o, 1);
    @(negedge clk_i) status_clr_i = 1'b1;
    @(negedge clk_i) status_clr_i = 1'b0;
    chk("R8 cleared", nmi_status_o, 0);
  endtask

  initial begin
    t_reset();
    t_blank_irq();
    t_mask();
    t_lms_rows();
    t_wrap();
    t_dma_off();
    t_status();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule